// File: doc/BRIEF.md
# Up-Counting Interval Timer with Posted Register Writes

This block is a 32-bit interval timer that sits on a simple register bus. A counter counts up on every tick and overflows when it passes its all-ones value. Software programs a start value, a reload value and a compare value, and it can stop or start the counter. An interrupt line and a separate wake line are raised when the overflow or compare-match events it has enabled occur.

Writes to the registers that drive timing (control, counter, reload, reload trigger and compare value) are posted. Each one spends a fixed two clock cycles in a delay slot before it takes effect. A bitmap register shows which of those writes are still in flight, so a driver can poll it before it depends on a new setting. Event flags are sticky and are cleared by writing ones to them. Writes to the enable registers and to the flag register take effect at once.

Top module: `upt_timer`

## Requirements
- R1: After reset the control, counter, reload, compare, flag, enable and pending registers all read 0, and `irq` and `wake` are low.
- R2: A bus write to a posted register sets its pending bit (bit 0 control at 0x24, bit 1 counter at 0x28, bit 2 reload at 0x2C, bit 3 trigger at 0x30, bit 4 compare at 0x38, read at 0x34) for exactly two cycles. The register keeps its old value until the second clock edge after the write, and then reads the new value.
- R3: While control bit 0 is 1 and the prescaler is off, the counter increments by one each cycle. While bit 0 is 0 the counter holds its value.
- R4: A counter loaded with 0xFFFFFFFF−N overflows on tick N+1. With control bit 5 set, a tick occurs once every 2^(P+1) cycles, where P is control bits 4:2. With bit 5 clear, the P field has no effect.
- R5: On overflow with control bit 1 set, the counter takes the reload value and keeps running. With bit 1 clear, the counter wraps to 0 and control bit 0 is cleared.
- R6: A write of any value to the trigger register (0x30) loads the counter from the reload register when that write takes effect.
- R7: With control bit 6 set, flag bit 0 is set on a tick that makes the counter equal the compare register. With bit 6 clear, no match flag is raised.
- R8: The flag register (0x18) has bit 0 match, bit 1 overflow and bit 2 capture. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high while any flag is set whose bit is also set in the interrupt-enable register (0x1C). `wake` does the same using the wake-enable register (0x20).
- R10: The ID register (0x00) returns a revision byte in bits 7:0, with the major number in bits 7:4 and the minor number in bits 3:0. The default revision is 2.1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt request |
| wake | output | 1 | Level wake request |

## Verification
A fault in the posting slots shows up at once in the pending bitmap, in the cycle right after the write. It also shows two cycles later, when the register reads back too early, too late or not at all. A fault in the tick or prescale state moves the first `irq` edge away from its computed cycle, and the bench measures that edge exactly for several prescale settings. A fault in the overflow or compare logic leaves the wrong counter value, run bit or flag bits visible on the same negative clock edge on which `irq` rises.

// File: rtl/upt_pkg.sv
package upt_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int PTV_W   = 3;
    localparam int FLAG_W  = 3;
    localparam int NUM_POST = 5;
    localparam int POST_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFF_ID     = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_FLAGS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_WEN    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_TRIG   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_CMP    = 8'h38;

    // Index of each posted register in the pending bitmap.
    typedef enum int {
        PW_CTRL   = 0,
        PW_COUNT  = 1,
        PW_RELOAD = 2,
        PW_TRIG   = 3,
        PW_CMP    = 4
    } post_idx_e;

    // Index of each event flag.
    typedef enum int {
        FL_MATCH = 0,
        FL_OVF   = 1,
        FL_CAP   = 2
    } flag_idx_e;

    // Control word; the packed order matches the bus bit positions 6..0.
    typedef struct packed {
        logic             cmp_en;
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
        logic             auto_rl;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [ADDR_W-1:0] post_off(input int idx);
        case (idx)
            PW_CTRL:   return OFF_CTRL;
            PW_COUNT:  return OFF_COUNT;
            PW_RELOAD: return OFF_RELOAD;
            PW_TRIG:   return OFF_TRIG;
            default:   return OFF_CMP;
        endcase
    endfunction

endpackage

// File: rtl/upt_post_slot.sv
module upt_post_slot #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         commit,
    output logic [W-1:0] commit_data,
    output logic         busy
);
    logic [STAGES-1:0] vld;
    logic [W-1:0]      dat [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            dat[0] <= '0;
        end else begin
            vld    <= {vld[STAGES-2:0], wr_en};
            dat[0] <= wr_data;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) dat[s] <= '0;
            else     dat[s] <= dat[s-1];
        end
    end

    assign commit      = vld[STAGES-1];
    assign commit_data = dat[STAGES-1];
    assign busy        = |vld;
endmodule

// File: rtl/upt_prescale.sv
module upt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    localparam int PCNT_W = 1 << PTV_W;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] last;
    logic              wrap;

    // Terminal count 2^(ptv+1)-1 as a right-shifted all-ones word.
    assign last = {PCNT_W{1'b1}} >> (PCNT_W - 1 - int'(ptv));
    assign wrap = (pcnt == last);
    assign tick = run && (!pre_en || wrap);

    always_ff @(posedge clk) begin
        if (rst || !run || !pre_en) pcnt <= '0;
        else if (wrap)              pcnt <= '0;
        else                        pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/upt_count.sv
module upt_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         set_en,
    input  logic [W-1:0] set_val,
    input  logic         trig_ld,
    input  logic [W-1:0] reload,
    input  logic         auto_rl,
    input  logic         cmp_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         ovf_ev,
    output logic         match_ev
);
    logic         step;
    logic         at_top;
    logic [W-1:0] next_val;

    assign step     = tick && !set_en && !trig_ld;
    assign at_top   = &cnt;
    assign next_val = at_top ? (auto_rl ? reload : '0) : cnt + 1'b1;
    assign ovf_ev   = step && at_top;
    assign match_ev = step && cmp_en && (next_val == cmp_val);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (set_en)  cnt <= set_val;
        else if (trig_ld) cnt <= reload;
        else if (step)    cnt <= next_val;
    end
endmodule

// File: rtl/upt_timer.sv
module upt_timer
    import upt_pkg::*;
#(
    parameter logic [7:0] REV = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);
    logic                wr_hit;
    logic [NUM_POST-1:0] commit;
    logic [NUM_POST-1:0] pend;
    logic [DATA_W-1:0]   cdata [NUM_POST];

    ctrl_t               ctrl_q;
    logic [DATA_W-1:0]   reload_q;
    logic [DATA_W-1:0]   cmp_q;
    logic [DATA_W-1:0]   cnt_q;
    logic [FLAG_W-1:0]   flags_q;
    logic [FLAG_W-1:0]   ien_q;
    logic [FLAG_W-1:0]   wen_q;
    logic [FLAG_W-1:0]   ev;
    logic [FLAG_W-1:0]   clr;
    logic                tick;
    logic                ovf_ev;
    logic                match_ev;

    assign wr_hit = bus_sel && bus_wr;

    for (genvar g = 0; g < NUM_POST; g++) begin : g_post
        upt_post_slot #(.W(DATA_W), .STAGES(POST_STAGES)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (wr_hit && (bus_addr == post_off(g))),
            .wr_data     (bus_wdata),
            .commit      (commit[g]),
            .commit_data (cdata[g]),
            .busy        (pend[g])
        );
    end

    upt_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .pre_en (ctrl_q.pre_en),
        .ptv    (ctrl_q.ptv),
        .tick   (tick)
    );

    upt_count #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .set_en   (commit[PW_COUNT]),
        .set_val  (cdata[PW_COUNT]),
        .trig_ld  (commit[PW_TRIG]),
        .reload   (reload_q),
        .auto_rl  (ctrl_q.auto_rl),
        .cmp_en   (ctrl_q.cmp_en),
        .cmp_val  (cmp_q),
        .cnt      (cnt_q),
        .ovf_ev   (ovf_ev),
        .match_ev (match_ev)
    );

    // Posted registers held outside the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else begin
            if (commit[PW_CTRL])
                ctrl_q <= ctrl_t'(cdata[PW_CTRL][CTRL_W-1:0]);
            else if (ovf_ev && !ctrl_q.auto_rl)
                ctrl_q.run <= 1'b0;
            if (commit[PW_RELOAD]) reload_q <= cdata[PW_RELOAD];
            if (commit[PW_CMP])    cmp_q    <= cdata[PW_CMP];
        end
    end

    // Event flags; a new event wins over a clear in the same cycle.
    always_comb begin
        ev           = '0;
        ev[FL_MATCH] = match_ev;
        ev[FL_OVF]   = ovf_ev;
        clr = (wr_hit && bus_addr == OFF_FLAGS) ? bus_wdata[FLAG_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ien_q   <= '0;
            wen_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr) | ev;
            if (wr_hit && bus_addr == OFF_IEN) ien_q <= bus_wdata[FLAG_W-1:0];
            if (wr_hit && bus_addr == OFF_WEN) wen_q <= bus_wdata[FLAG_W-1:0];
        end
    end

    assign irq  = |(flags_q & ien_q);
    assign wake = |(flags_q & wen_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_ID:     bus_rdata[7:0]          = REV;
            OFF_FLAGS:  bus_rdata[FLAG_W-1:0]   = flags_q;
            OFF_IEN:    bus_rdata[FLAG_W-1:0]   = ien_q;
            OFF_WEN:    bus_rdata[FLAG_W-1:0]   = wen_q;
            OFF_CTRL:   bus_rdata[CTRL_W-1:0]   = ctrl_q;
            OFF_COUNT:  bus_rdata               = cnt_q;
            OFF_RELOAD: bus_rdata               = reload_q;
            OFF_PEND:   bus_rdata[NUM_POST-1:0] = pend;
            OFF_CMP:    bus_rdata               = cmp_q;
            default:    bus_rdata               = '0;
        endcase
    end
endmodule

// File: rtl/upt_timer_chk.sv
module upt_timer_chk
    import upt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_POST-1:0] pend,
    input logic [NUM_POST-1:0] commit,
    input logic                run,
    input logic                auto_rl,
    input logic                tick,
    input logic [DATA_W-1:0]   cnt,
    input logic [FLAG_W-1:0]   flags,
    input logic                irq
);
    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFF_RELOAD) |=> pend[PW_RELOAD]);

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !commit[PW_COUNT] && !commit[PW_TRIG]) |=> $stable(cnt));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt) && !auto_rl && !commit[PW_COUNT] && !commit[PW_TRIG]
         && !commit[PW_CTRL]) |=> !run);

    // R8
    w1c_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFF_FLAGS && bus_wdata[FL_OVF]
         && !(tick && (&cnt))) |=> !flags[FL_OVF]);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
endmodule

bind upt_timer upt_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend),
    .commit    (commit),
    .run       (ctrl_q.run),
    .auto_rl   (ctrl_q.auto_rl),
    .tick      (tick),
    .cnt       (cnt_q),
    .flags     (flags_q),
    .irq       (irq)
);

// File: tb/upt_timer_tb.sv
`timescale 1ns/100ps
module upt_timer_tb;

    localparam logic [7:0] A_ID = 8'h00, A_FLG = 8'h18, A_IEN = 8'h1C,
        A_WEN = 8'h20, A_CTL = 8'h24, A_CNT = 8'h28, A_RLD = 8'h2C,
        A_TRG = 8'h30, A_PND = 8'h34, A_CMP = 8'h38;

    // Prescale vectors: enable, P field, N, cycles from control write to irq.
    localparam int NV = 6;
    localparam int V_PRE [NV] = '{0, 0, 1, 1, 1, 1};
    localparam int V_PTV [NV] = '{0, 3, 0, 2, 7, 1};
    localparam int V_N   [NV] = '{0, 5, 0, 1, 0, 2};
    localparam int V_EXP [NV] = '{3, 8, 4, 18, 258, 14};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    upt_timer u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        logic [31:0] d;
        int k;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(A_CTL, d); chk("R1 ctrl", d, 0);
        rd(A_CNT, d); chk("R1 count", d, 0);
        rd(A_FLG, d); chk("R1 flags", d, 0);
        rd(A_PND, d); chk("R1 pending", d, 0);
        chk("R1 irq/wake", {30'b0, irq, wake}, 0);

        // R10 revision fields
        rd(A_ID, d);
        chk("R10 major", d[7:4], 2);
        chk("R10 minor", d[3:0], 1);

        // R2 posted reload write
        wr(A_RLD, 32'h1234);
        rd(A_PND, d); chk("R2 pend c0", d, 32'h4);
        rd(A_RLD, d); chk("R2 old c0", d, 0);
        idle(1);
        rd(A_PND, d); chk("R2 pend c1", d, 32'h4);
        rd(A_RLD, d); chk("R2 old c1", d, 0);
        idle(1);
        rd(A_PND, d); chk("R2 pend c2", d, 0);
        rd(A_RLD, d); chk("R2 new c2", d, 32'h1234);
        wr(A_CMP, 32'h5);
        rd(A_PND, d); chk("R2 cmp pend", d, 32'h10);
        idle(3);

        // R6 trigger load
        wr(A_RLD, 32'hABCD0000); idle(3);
        wr(A_TRG, 32'h0);
        rd(A_PND, d); chk("R6 trig pend", d, 32'h8);
        rd(A_CNT, d); chk("R6 before", d, 0);
        idle(2);
        rd(A_CNT, d); chk("R6 loaded", d, 32'hABCD0000);

        // R3 counting and hold
        wr(A_CNT, 100); idle(3);
        wr(A_CTL, 1);
        idle(5);
        rd(A_CNT, d); chk("R3 counting", d, 103);
        wr(A_CTL, 0);
        idle(4);
        rd(A_CNT, d); chk("R3 stopped", d, 107);
        idle(3);
        rd(A_CNT, d); chk("R3 holds", d, 107);

        // R4 / R5 vector table: one-shot overflow timing
        wr(A_IEN, 2);
        for (int v = 0; v < NV; v++) begin
            wr(A_CTL, 0);
            wr(A_FLG, 7);
            wr(A_CNT, 32'hFFFF_FFFF - 32'(V_N[v]));
            idle(3);
            wr(A_CTL, 32'(1 | (V_PRE[v] << 5) | (V_PTV[v] << 2)));
            wait_irq(k);
            chk($sformatf("R4 vec%0d cycles", v), 32'(k), 32'(V_EXP[v]));
            rd(A_CTL, d); chk("R5 oneshot run", {31'b0, d[0]}, 0);
            rd(A_CNT, d); chk("R5 oneshot wrap", d, 0);
        end

        // R5 auto-reload
        wr(A_RLD, 32'hFFFF_FFF0);
        wr(A_FLG, 7);
        wr(A_CNT, 32'hFFFF_FFFE);
        idle(3);
        wr(A_CTL, 3);
        wait_irq(k);
        chk("R5 reload cycles", 32'(k), 4);
        rd(A_CNT, d); chk("R5 reload value", d, 32'hFFFF_FFF0);
        rd(A_CTL, d); chk("R5 still running", {31'b0, d[0]}, 1);
        idle(1);
        rd(A_CNT, d); chk("R5 continues", d, 32'hFFFF_FFF1);
        wr(A_CTL, 0); idle(3);

        // R7 compare match
        wr(A_IEN, 1);
        wr(A_FLG, 7);
        wr(A_CMP, 15);
        wr(A_CNT, 10);
        idle(3);
        wr(A_CTL, 32'h41);
        wait_irq(k);
        chk("R7 match cycles", 32'(k), 7);
        rd(A_FLG, d); chk("R7 match flag", d, 1);
        wr(A_CTL, 0); idle(3);
        wr(A_FLG, 7);
        wr(A_CNT, 10); idle(3);
        wr(A_CTL, 1);
        idle(12);
        rd(A_FLG, d); chk("R7 compare off", d, 0);
        chk("R7 no irq", {31'b0, irq}, 0);
        wr(A_CTL, 0); idle(3);

        // R8 / R9 flags, clearing and outputs
        wr(A_IEN, 0);
        wr(A_FLG, 7);
        wr(A_CMP, 32'hFFFF_FFFF);
        wr(A_CNT, 32'hFFFF_FFFE);
        idle(3);
        wr(A_CTL, 32'h41);
        idle(6);
        rd(A_FLG, d); chk("R8 both flags", d, 3);
        chk("R9 masked irq", {31'b0, irq}, 0);
        wr(A_FLG, 0);
        rd(A_FLG, d); chk("R8 zero write", d, 3);
        wr(A_IEN, 2);
        chk("R9 irq on", {31'b0, irq}, 1);
        wr(A_WEN, 1);
        chk("R9 wake on", {31'b0, wake}, 1);
        wr(A_FLG, 1);
        rd(A_FLG, d); chk("R8 clear match", d, 2);
        chk("R9 wake off", {31'b0, wake}, 0);
        chk("R9 irq kept", {31'b0, irq}, 1);
        wr(A_FLG, 2);
        rd(A_FLG, d); chk("R8 clear ovf", d, 0);
        chk("R9 irq off", {31'b0, irq}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule